// File: doc/BRIEF.md
# Direct-Mapped Write-Through Data Cache

This block sits between a processor load/store port and a slower, word-wide memory port. It keeps 1024 single-word lines. Each line has a valid flag, a 20-bit address tag and a 32-bit data word. A load that finds its line valid and its tag equal completes without waiting, and the data appears one cycle later. A load that misses holds the processor stalled while the word is read from memory. The word is then written into the line, and the load completes on the following cycle as a hit.

Stores always complete into the cache. This is true on a hit and on a miss, because a line is one word wide and there is nothing to fetch first. Each store is also posted into a four-entry write queue. The queue drains to memory in order, on its own, one word per memory handshake.

A load miss never reads memory while the queue holds stores. This keeps a word that was overwritten in the line, but is still queued, from being read stale. The memory port carries one transaction at a time. The request and its address, direction and data stay steady until the acknowledge.

Top module: `wt_cache_top`

## Requirements
- R1: After reset every line is invalid, so the first load to any address misses. The write queue is empty, so `mem_req_o` is low.
- R2: Byte address bits 1..0 play no part in lookup. Bits 11..2 pick the line, and bits 31..12 are the tag.
- R3: A load hits only when the line is valid and its stored tag equals address bits 31..12. Two addresses with the same bits 11..2 but different upper bits evict each other.
- R4: A load hit is not stalled. `cpu_rvalid_o` is high, with the line data on `cpu_rdata_o`, in the cycle after the load is accepted.
- R5: A load miss raises `cpu_stall_o` and issues one memory read (`mem_we_o` low) at the word-aligned address. It returns the memory word and leaves the line valid, so a repeat load hits with no memory read.
- R6: A store, hit or miss, writes data and tag into the line and sets it valid without reading memory. A later load of that address hits with the stored data.
- R7: Every accepted store reaches memory as one write (`mem_we_o` high) with the same word address and data. Stores reach memory in the order they were accepted.
- R8: A store is accepted without stall while fewer than 4 stores are queued. When 4 are queued, a new store stalls until an entry has drained.
- R9: A load miss issues its memory read only after the write queue is empty, so it returns the most recent store to that address.
- R10: While `mem_req_o` is high and `mem_ack_i` is low, the request, `mem_we_o`, `mem_addr_o` and `mem_wdata_o` stay unchanged into the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cpu_req_i | input | 1 | Processor access request, held while stalled |
| cpu_we_i | input | 1 | 1 = store, 0 = load |
| cpu_addr_i | input | 32 | Byte address |
| cpu_wdata_i | input | 32 | Store data |
| cpu_stall_o | output | 1 | Access cannot complete this cycle |
| cpu_rvalid_o | output | 1 | Load data valid, one cycle after acceptance |
| cpu_rdata_o | output | 32 | Load data |
| mem_req_o | output | 1 | Memory transaction request |
| mem_we_o | output | 1 | 1 = queued write, 0 = line fill read |
| mem_addr_o | output | 32 | Word-aligned memory byte address |
| mem_wdata_o | output | 32 | Memory write data |
| mem_ack_i | input | 1 | One-cycle completion of the current transaction |
| mem_rdata_i | input | 32 | Read data, valid with `mem_ack_i` |

## Verification
A load miss can arrive while queued stores are still draining, so the line fill and the queue drain compete for the one memory port. The bench provokes this by holding the memory model's acknowledge while two stores to the same line index are queued. It then issues a load of the older, evicted address and releases memory a number of cycles later. The load is judged correct when three things hold: it returns the older store's data, it stalls for at least the held interval, and exactly one memory read is seen after both queued writes have been logged. A second collision is a store arriving while the queue is full and memory is blocked. The stall is sampled before and after the release.

// File: rtl/wt_cache_pkg.sv
package wt_cache_pkg;
  localparam int unsigned ADDR_W = 32;
  localparam int unsigned DATA_W = 32;
  localparam int unsigned WADDR_W = ADDR_W - 2;

  typedef enum logic [0:0] {
    ST_IDLE = 1'b0,
    ST_FILL = 1'b1
  } fill_state_e;

  typedef struct packed {
    logic [WADDR_W-1:0] waddr;
    logic [DATA_W-1:0]  data;
  } wb_entry_t;
endpackage

// File: rtl/wt_cache_store.sv
module wt_cache_store #(
  parameter int unsigned INDEX_W = 10,
  parameter int unsigned TAG_W   = 20,
  parameter int unsigned DATA_W  = 32
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [INDEX_W-1:0] rd_idx_i,
  output logic               rd_valid_o,
  output logic [TAG_W-1:0]   rd_tag_o,
  output logic [DATA_W-1:0]  rd_data_o,
  input  logic               wr_en_i,
  input  logic [INDEX_W-1:0] wr_idx_i,
  input  logic [TAG_W-1:0]   wr_tag_i,
  input  logic [DATA_W-1:0]  wr_data_i
);
  localparam int unsigned LINES = 1 << INDEX_W;

  logic [LINES-1:0]  valid_q;
  logic [TAG_W-1:0]  tag_q  [LINES];
  logic [DATA_W-1:0] data_q [LINES];

  // only valid flags need reset
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= '0;
    end else if (wr_en_i) begin
      valid_q[wr_idx_i] <= 1'b1;
    end
  end

  always_ff @(posedge clk_i) begin
    if (wr_en_i) begin
      tag_q[wr_idx_i]  <= wr_tag_i;
      data_q[wr_idx_i] <= wr_data_i;
    end
  end

  assign rd_valid_o = valid_q[rd_idx_i];
  assign rd_tag_o   = tag_q[rd_idx_i];
  assign rd_data_o  = data_q[rd_idx_i];
endmodule

// File: rtl/wt_cache_wbuf.sv
module wt_cache_wbuf
  import wt_cache_pkg::*;
#(
  parameter int unsigned DEPTH = 4,
  localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             push_i,
  input  wb_entry_t        push_data_i,
  input  logic             pop_i,
  output wb_entry_t        head_o,
  output logic             empty_o,
  output logic             full_o,
  output logic [CNT_W-1:0] count_o
);
  wb_entry_t        slot_q [DEPTH];
  logic [PTR_W-1:0] wr_ptr_q, rd_ptr_q;
  logic [CNT_W-1:0] count_q;
  logic             do_push, do_pop;

  function automatic logic [PTR_W-1:0] ptr_next(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign full_o  = (count_q == CNT_W'(DEPTH));
  assign empty_o = (count_q == '0);
  assign do_push = push_i && !full_o;
  assign do_pop  = pop_i && !empty_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      count_q  <= '0;
    end else begin
      if (do_push) wr_ptr_q <= ptr_next(wr_ptr_q);
      if (do_pop)  rd_ptr_q <= ptr_next(rd_ptr_q);
      case ({do_push, do_pop})
        2'b10:   count_q <= count_q + 1'b1;
        2'b01:   count_q <= count_q - 1'b1;
        default: count_q <= count_q;
      endcase
    end
  end

  always_ff @(posedge clk_i) begin
    if (do_push) slot_q[wr_ptr_q] <= push_data_i;
  end

  assign head_o  = slot_q[rd_ptr_q];
  assign count_o = count_q;
endmodule

// File: rtl/wt_cache_ctrl.sv
module wt_cache_ctrl
  import wt_cache_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic cpu_req_i,
  input  logic cpu_we_i,
  input  logic hit_i,
  input  logic wb_full_i,
  input  logic wb_empty_i,
  input  logic mem_ack_i,
  output logic stall_o,
  output logic rd_accept_o,
  output logic wr_accept_o,
  output logic fill_issue_o,
  output logic fill_done_o
);
  fill_state_e state_q, state_d;
  logic rd_req, wr_req, idle;

  assign rd_req = cpu_req_i && !cpu_we_i;
  assign wr_req = cpu_req_i && cpu_we_i;
  assign idle   = (state_q == ST_IDLE);

  // fill waits until queued stores have left
  assign fill_issue_o = (state_q == ST_FILL) && wb_empty_i;
  assign fill_done_o  = fill_issue_o && mem_ack_i;

  assign rd_accept_o = idle && rd_req && hit_i;
  assign wr_accept_o = idle && wr_req && !wb_full_i;

  always_comb begin
    if (!idle) stall_o = cpu_req_i;
    else       stall_o = (rd_req && !hit_i) || (wr_req && wb_full_i);
  end

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: if (rd_req && !hit_i) state_d = ST_FILL;
      ST_FILL: if (fill_done_o)      state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_IDLE;
    else         state_q <= state_d;
  end
endmodule

// File: rtl/wt_cache_top.sv
module wt_cache_top
  import wt_cache_pkg::*;
#(
  parameter int unsigned INDEX_W  = 10,
  parameter int unsigned WB_DEPTH = 4,
  localparam int unsigned TAG_W    = ADDR_W - INDEX_W - 2,
  localparam int unsigned WB_CNT_W = $clog2(WB_DEPTH + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cpu_req_i,
  input  logic              cpu_we_i,
  input  logic [ADDR_W-1:0] cpu_addr_i,
  input  logic [DATA_W-1:0] cpu_wdata_i,
  output logic              cpu_stall_o,
  output logic              cpu_rvalid_o,
  output logic [DATA_W-1:0] cpu_rdata_o,
  output logic              mem_req_o,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [DATA_W-1:0] mem_wdata_o,
  input  logic              mem_ack_i,
  input  logic [DATA_W-1:0] mem_rdata_i
);
  logic [INDEX_W-1:0] idx;
  logic [TAG_W-1:0]   tag;
  logic               unused_offset;

  logic               line_valid;
  logic [TAG_W-1:0]   line_tag;
  logic [DATA_W-1:0]  line_data;
  logic               hit;

  logic               rd_accept, wr_accept, fill_issue, fill_done;
  logic               line_we;
  logic [DATA_W-1:0]  line_wdata;

  wb_entry_t           wb_in, wb_head;
  logic                wb_empty, wb_full, wb_pop;
  logic [WB_CNT_W-1:0] wb_count;

  assign idx           = cpu_addr_i[INDEX_W+1:2];
  assign tag           = cpu_addr_i[ADDR_W-1:INDEX_W+2];
  assign unused_offset = ^cpu_addr_i[1:0];

  wt_cache_store #(
    .INDEX_W(INDEX_W),
    .TAG_W  (TAG_W),
    .DATA_W (DATA_W)
  ) i_store (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .rd_idx_i  (idx),
    .rd_valid_o(line_valid),
    .rd_tag_o  (line_tag),
    .rd_data_o (line_data),
    .wr_en_i   (line_we),
    .wr_idx_i  (idx),
    .wr_tag_i  (tag),
    .wr_data_i (line_wdata)
  );

  assign hit = line_valid && (line_tag == tag);

  wt_cache_ctrl i_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .cpu_req_i   (cpu_req_i),
    .cpu_we_i    (cpu_we_i),
    .hit_i       (hit),
    .wb_full_i   (wb_full),
    .wb_empty_i  (wb_empty),
    .mem_ack_i   (mem_ack_i),
    .stall_o     (cpu_stall_o),
    .rd_accept_o (rd_accept),
    .wr_accept_o (wr_accept),
    .fill_issue_o(fill_issue),
    .fill_done_o (fill_done)
  );

  // stores and fills share the line write port; never in the same cycle
  assign line_we    = wr_accept || fill_done;
  assign line_wdata = fill_done ? mem_rdata_i : cpu_wdata_i;

  assign wb_in.waddr = cpu_addr_i[ADDR_W-1:2];
  assign wb_in.data  = cpu_wdata_i;
  assign wb_pop      = !wb_empty && mem_ack_i;

  wt_cache_wbuf #(
    .DEPTH(WB_DEPTH)
  ) i_wbuf (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .push_i     (wr_accept),
    .push_data_i(wb_in),
    .pop_i      (wb_pop),
    .head_o     (wb_head),
    .empty_o    (wb_empty),
    .full_o     (wb_full),
    .count_o    (wb_count)
  );

  // queued writes own the port until empty, then a fill may go
  assign mem_req_o   = !wb_empty || fill_issue;
  assign mem_we_o    = !wb_empty;
  assign mem_addr_o  = wb_empty ? {cpu_addr_i[ADDR_W-1:2], 2'b00} : {wb_head.waddr, 2'b00};
  assign mem_wdata_o = wb_head.data;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cpu_rvalid_o <= 1'b0;
      cpu_rdata_o  <= '0;
    end else begin
      cpu_rvalid_o <= rd_accept;
      if (rd_accept) cpu_rdata_o <= line_data;
    end
  end
endmodule

// File: rtl/wt_cache_chk.sv
module wt_cache_chk #(
  parameter int unsigned WB_DEPTH = 4,
  localparam int unsigned WB_CNT_W = $clog2(WB_DEPTH + 1)
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic                cpu_req_i,
  input logic                cpu_we_i,
  input logic                cpu_stall_o,
  input logic                cpu_rvalid_o,
  input logic                mem_req_o,
  input logic                mem_we_o,
  input logic [31:0]         mem_addr_o,
  input logic [31:0]         mem_wdata_o,
  input logic                mem_ack_i,
  input logic                wb_empty,
  input logic [WB_CNT_W-1:0] wb_count
);
  AST_RD_HIT_DATA: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cpu_req_i && !cpu_we_i && !cpu_stall_o) |=> cpu_rvalid_o); // R4

  AST_FILL_STALLS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && !mem_we_o && cpu_req_i) |-> cpu_stall_o); // R5

  AST_STORE_FULL_STALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cpu_req_i && cpu_we_i && (wb_count == WB_CNT_W'(WB_DEPTH))) |-> cpu_stall_o); // R8

  AST_QUEUE_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wb_count <= WB_CNT_W'(WB_DEPTH)); // R8

  AST_FILL_AFTER_DRAIN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && !mem_we_o) |-> wb_empty); // R9

  AST_MEM_REQ_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && !mem_ack_i) |=> (mem_req_o && $stable(mem_we_o) &&
      $stable(mem_addr_o) && $stable(mem_wdata_o))); // R10
endmodule

bind wt_cache_top wt_cache_chk #(.WB_DEPTH(WB_DEPTH)) i_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .cpu_req_i   (cpu_req_i),
  .cpu_we_i    (cpu_we_i),
  .cpu_stall_o (cpu_stall_o),
  .cpu_rvalid_o(cpu_rvalid_o),
  .mem_req_o   (mem_req_o),
  .mem_we_o    (mem_we_o),
  .mem_addr_o  (mem_addr_o),
  .mem_wdata_o (mem_wdata_o),
  .mem_ack_i   (mem_ack_i),
  .wb_empty    (wb_empty),
  .wb_count    (wb_count)
);

// File: tb/test_wt_cache_top.sv
module test_wt_cache_top;
  localparam int MEM_LAT = 3;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0, we = 1'b0;
  logic [31:0] addr = '0, wdata = '0;
  logic        stall, rvalid;
  logic [31:0] rdata;
  logic        mem_req, mem_we, mem_ack;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  logic        hold_mem = 1'b0;
  logic [31:0] mem_arr [4096];
  logic [31:0] log_addr [64];
  logic [31:0] log_data [64];
  int          wr_cnt = 0;
  int          rd_cnt = 0;
  int          wr_at_rd = 0;
  int          lat_cnt = 0;

  always #5 clk = ~clk;

  wt_cache_top i_wt_cache_top (
    .clk_i(clk), .rst_ni(rst_n),
    .cpu_req_i(req), .cpu_we_i(we), .cpu_addr_i(addr), .cpu_wdata_i(wdata),
    .cpu_stall_o(stall), .cpu_rvalid_o(rvalid), .cpu_rdata_o(rdata),
    .mem_req_o(mem_req), .mem_we_o(mem_we), .mem_addr_o(mem_addr),
    .mem_wdata_o(mem_wdata), .mem_ack_i(mem_ack), .mem_rdata_i(mem_rdata)
  );

  function automatic logic [31:0] mem_init(input logic [31:0] a);
    return 32'hA5A5_0000 | {20'b0, a[13:2]};
  endfunction

  // memory model: fixed latency, one-cycle ack
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mem_ack   <= 1'b0;
      mem_rdata <= '0;
      lat_cnt   <= 0;
      for (int i = 0; i < 4096; i++) mem_arr[i] <= mem_init(32'(i) << 2);
    end else begin
      mem_ack <= 1'b0;
      if (mem_req && !mem_ack && !hold_mem) begin
        if (lat_cnt == MEM_LAT - 1) begin
          lat_cnt <= 0;
          mem_ack <= 1'b1;
          if (mem_we) begin
            mem_arr[mem_addr[13:2]] <= mem_wdata;
            if (wr_cnt < 64) begin
              log_addr[wr_cnt] <= mem_addr;
              log_data[wr_cnt] <= mem_wdata;
            end
            wr_cnt <= wr_cnt + 1;
          end else begin
            mem_rdata <= mem_arr[mem_addr[13:2]];
            rd_cnt    <= rd_cnt + 1;
            wr_at_rd  <= wr_cnt;
          end
        end else begin
          lat_cnt <= lat_cnt + 1;
        end
      end
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic do_read(input logic [31:0] a, output logic [31:0] d, output int stalls);
    @(negedge clk);
    req = 1'b1; we = 1'b0; addr = a; stalls = 0;
    #1;
    while (stall) begin
      @(negedge clk); #1;
      stalls++;
    end
    @(negedge clk);
    req = 1'b0;
    d = rvalid ? rdata : 32'hxxxx_xxxx;
  endtask

  task automatic do_write(input logic [31:0] a, input logic [31:0] d, output int stalls);
    @(negedge clk);
    req = 1'b1; we = 1'b1; addr = a; wdata = d; stalls = 0;
    #1;
    while (stall) begin
      @(negedge clk); #1;
      stalls++;
    end
    @(negedge clk);
    req = 1'b0; we = 1'b0;
  endtask

  task automatic wait_writes(input int n);
    while (wr_cnt < n) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic t_reset;
    @(negedge clk);
    chk("R1 mem_req after reset", 32'(mem_req), 32'd0);
    chk("R1 stall after reset", 32'(stall), 32'd0);
    chk("R1 rvalid after reset", 32'(rvalid), 32'd0);
  endtask

  task automatic t_cold_miss;
    logic [31:0] d; int st; int r0;
    r0 = rd_cnt;
    do_read(32'h0000_1008, d, st);
    chk("R1 R5 cold load stalls", 32'(st > 0), 32'd1);
    chk("R5 fill data", d, mem_init(32'h0000_1008));
    chk("R5 one memory read", 32'(rd_cnt - r0), 32'd1);
    do_read(32'h0000_1008, d, st);
    chk("R4 hit no stall", 32'(st), 32'd0);
    chk("R4 hit data", d, mem_init(32'h0000_1008));
    chk("R5 no read on hit", 32'(rd_cnt - r0), 32'd1);
  endtask

  task automatic t_offset;
    logic [31:0] d; int st;
    do_read(32'h0000_100B, d, st);
    chk("R2 offset ignored stall", 32'(st), 32'd0);
    chk("R2 offset ignored data", d, mem_init(32'h0000_1008));
  endtask

  task automatic t_conflict;
    logic [31:0] d; int st; int r0;
    r0 = rd_cnt;
    do_read(32'h0000_2008, d, st);
    chk("R3 other tag misses", 32'(st > 0), 32'd1);
    chk("R3 other tag data", d, mem_init(32'h0000_2008));
    do_read(32'h0000_1008, d, st);
    chk("R3 evicted line misses", 32'(st > 0), 32'd1);
    chk("R3 evicted data", d, mem_init(32'h0000_1008));
    chk("R3 two reads", 32'(rd_cnt - r0), 32'd2);
  endtask

  task automatic t_write_miss;
    logic [31:0] d; int st; int r0; int w0;
    r0 = rd_cnt; w0 = wr_cnt;
    do_write(32'h0000_3010, 32'hDEAD_0001, st);
    chk("R6 store miss no stall", 32'(st), 32'd0);
    do_read(32'h0000_3010, d, st);
    chk("R6 load after store hits", 32'(st), 32'd0);
    chk("R6 load after store data", d, 32'hDEAD_0001);
    chk("R6 no memory read", 32'(rd_cnt - r0), 32'd0);
    wait_writes(w0 + 1);
    chk("R7 drained addr", log_addr[w0], 32'h0000_3010);
    chk("R7 drained data", log_data[w0], 32'hDEAD_0001);
  endtask

  task automatic t_queue_full;
    int st; int tot; int w0;
    w0 = wr_cnt; tot = 0;
    hold_mem = 1'b1;
    for (int k = 0; k < 4; k++) begin
      do_write(32'h0000_4000 + 32'(k * 4), 32'hBEEF_0000 + 32'(k), st);
      tot += st;
    end
    chk("R8 four stores no stall", 32'(tot), 32'd0);
    @(negedge clk);
    req = 1'b1; we = 1'b1; addr = 32'h0000_4010; wdata = 32'hBEEF_0004;
    #1;
    chk("R8 fifth store stalls", 32'(stall), 32'd1);
    repeat (3) @(negedge clk);
    #1;
    chk("R8 still stalled while blocked", 32'(stall), 32'd1);
    hold_mem = 1'b0;
    while (stall) begin @(negedge clk); #1; end
    @(negedge clk);
    req = 1'b0; we = 1'b0;
    wait_writes(w0 + 5);
    for (int k = 0; k < 5; k++) begin
      chk("R7 order addr", log_addr[w0 + k], 32'h0000_4000 + 32'(k * 4));
      chk("R7 order data", log_data[w0 + k], 32'hBEEF_0000 + 32'(k));
    end
  endtask

  task automatic t_drain_before_fill;
    logic [31:0] d; int st; int r0; int w0;
    r0 = rd_cnt; w0 = wr_cnt;
    hold_mem = 1'b1;
    do_write(32'h0000_1020, 32'h1111_AAAA, st);
    do_write(32'h0000_2020, 32'h2222_BBBB, st);
    fork
      begin
        repeat (8) @(negedge clk);
        hold_mem = 1'b0;
      end
    join_none
    do_read(32'h0000_1020, d, st);
    chk("R9 load sees queued store", d, 32'h1111_AAAA);
    chk("R9 waited for drain", 32'(st >= 8), 32'd1);
    chk("R9 single fill read", 32'(rd_cnt - r0), 32'd1);
    chk("R9 both writes before fill", 32'(wr_at_rd), 32'(w0 + 2));
  endtask

  task automatic t_write_hit;
    logic [31:0] d; int st; int w0;
    w0 = wr_cnt;
    do_write(32'h0000_1008, 32'h5555_CCCC, st);
    chk("R6 store hit no stall", 32'(st), 32'd0);
    do_read(32'h0000_1008, d, st);
    chk("R6 store hit updates line", d, 32'h5555_CCCC);
    wait_writes(w0 + 1);
    chk("R7 store hit reaches memory", log_data[w0], 32'h5555_CCCC);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_cold_miss();
    t_offset();
    t_conflict();
    t_write_miss();
    t_queue_full();
    t_drain_before_fill();
    t_write_hit();
    repeat (5) @(negedge clk);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule